// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block is a slave-mode stereo serial audio port. It receives 24-bit left and right samples on a serial data input and sends 24-bit samples on a serial data output. An external source supplies the bit clock and the left/right word clock. Both clocks and the serial input pass through a synchronizer into the system clock domain, and the block detects clock edges there. A bit counter, cleared at every word-clock transition, numbers the bit periods (slots) of each half-frame.

The receive direction and the transmit direction each take their own 2-bit format code. One select bit, shared by both directions, chooses which bit-clock edge carries valid data. On the receive side, the left/right pair is delivered on parallel outputs with a one-cycle strobe once per frame. On the transmit side, a strobe captures a pair into a holding stage, and the serializer copies that pair at the start of each frame.

A slot is numbered from 0, and slot 0 is the first bit period after a word-clock transition. The right-justified codes assume 32 slots per channel, which means a bit clock of 64 times the sample rate. The high and low phases of the bit clock must each last at least 4 system clock cycles.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst` is high and after its release, until data arrives, `rx_valid`, `rx_left`, `rx_right` and `sdout` are 0. Both active formats start at code 00.
- R2: With code 00, the left channel is sent while `wclk` is low. The 24 bits occupy slots 1 to 24, MSB first.
- R3: With code 01, the left channel is sent while `wclk` is high. The 24 bits occupy slots 0 to 23, MSB first.
- R4: With code 10, the left channel is sent while `wclk` is high. The 24 bits occupy slots 8 to 31, MSB first, so the LSB falls in slot 31.
- R5: With code 11, the left channel is sent while `wclk` is high and 20 bits occupy slots 12 to 31. On receive they become sample bits 23..4 and bits 3..0 are zero. On transmit, sample bits 23..4 are sent and bits 3..0 are dropped.
- R6: `rx_fmt` governs only the receiver and `tx_fmt` governs only the transmitter, so the two may hold different codes at the same time.
- R7: With `bclk_fall` = 0, `sdin` and `wclk` are sampled on the rising `bclk` edge and `sdout` changes only after a falling edge. With `bclk_fall` = 1, the two edges swap roles.
- R8: In slots outside the data field of the active format, `sdout` is 0 and the `sdin` value has no effect on received samples.
- R9: `rx_valid` is a one-cycle pulse, raised once per frame after the sample edge of slot 0 of the following left half-frame. It carries the left and right samples of the frame that just ended. `rx_left` and `rx_right` change only with that pulse.
- R10: A new value on `rx_fmt` or `tx_fmt` takes effect at the next word-clock transition. The half-frame in progress finishes in the old format.
- R11: `tx_valid` captures `tx_left` and `tx_right` into a holding stage. The pair is copied for transmission at the word-clock transition that starts a left half-frame. A capture during a frame does not alter the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External bit clock |
| wclk | input | 1 | External left/right word clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out (registered) |
| bclk_fall | input | 1 | 0: data valid on rising bclk edge, 1: on falling edge |
| rx_fmt | input | 2 | Receive format code (00, 01, 10, 11 as in R2 to R5) |
| tx_fmt | input | 2 | Transmit format code (00, 01, 10, 11 as in R2 to R5) |
| rx_left | output | 24 | Received left sample |
| rx_right | output | 24 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| tx_valid | input | 1 | Captures `tx_left` and `tx_right` into the holding stage |

## Verification
The hardest situation to reach from the ports is a format change in the middle of a frame. It must take effect exactly at the next word-clock transition, so the left half of one frame is decoded in one layout and the right half in another. The stimulus drives a left-justified left half, changes both format inputs at slot 16, and then drives and decodes the right half in the right-justified layouts. The transmit pair is also reloaded in the middle of each right half, so a serializer that copies the new pair too early corrupts the bits still being sent. Slots outside the data field carry random input bits, which checks that those bits are ignored.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int SMP_W      = 24;
  localparam int NARROW_W   = 20;
  localparam int HALF_SLOTS = 32;
  localparam int CNT_W      = $clog2(HALF_SLOTS);
  localparam int IDX_W      = $clog2(SMP_W);

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ20 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // Map a slot number to a sample bit position for a format.
  function automatic slot_t slot_map(fmt_e f, logic [CNT_W-1:0] k);
    int first;
    int cnt;
    int j;
    slot_t s;
    unique case (f)
      FMT_I2S:  begin first = 1;                     cnt = SMP_W;    end
      FMT_LJ:   begin first = 0;                     cnt = SMP_W;    end
      FMT_RJ24: begin first = HALF_SLOTS - SMP_W;    cnt = SMP_W;    end
      default:  begin first = HALF_SLOTS - NARROW_W; cnt = NARROW_W; end
    endcase
    j = int'(k) - first;
    s.hit = (j >= 0) && (j < cnt);
    s.idx = s.hit ? IDX_W'(SMP_W - 1 - j) : '0;
    return s;
  endfunction

  // True when the word clock level marks the left channel.
  function automatic logic left_chan(fmt_e f, logic w);
    return (f == FMT_I2S) ? ~w : w;
  endfunction
endpackage

// File: rtl/asp_clk_sense.sv
module asp_clk_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic data_i,
  input  logic fall_sel,
  output logic smp_o,
  output logic lnc_o,
  output logic wclk_o,
  output logic data_o
);
  logic [STAGES:0]   bc_q;
  logic [STAGES-1:0] wc_q;
  logic [STAGES-1:0] dt_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_q <= '0;
      wc_q <= '0;
      dt_q <= '0;
    end else begin
      bc_q <= {bc_q[STAGES-1:0], bclk_i};
      wc_q <= {wc_q[STAGES-2:0], wclk_i};
      dt_q <= {dt_q[STAGES-2:0], data_i};
    end
  end

  // bc_q[STAGES-1] is aligned with the last word clock and data stage
  assign rise   = bc_q[STAGES-1] & ~bc_q[STAGES];
  assign fall   = ~bc_q[STAGES-1] & bc_q[STAGES];
  assign smp_o  = fall_sel ? fall : rise;
  assign lnc_o  = fall_sel ? rise : fall;
  assign wclk_o = wc_q[STAGES-1];
  assign data_o = dt_q[STAGES-1];
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_i,
  input  logic             wclk_i,
  input  logic             data_i,
  input  fmt_e             fmt_i,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             valid_o
);
  fmt_e             act_fmt, use_fmt;
  logic             prev_w, synced, left_ok, edge_w, done_left;
  logic [CNT_W-1:0] k_q, k_now, k_nxt;
  logic [SMP_W-1:0] cur_q, nxt_word, left_hold;
  slot_t            sm;

  always_comb begin
    edge_w    = (wclk_i != prev_w);
    use_fmt   = edge_w ? fmt_i : act_fmt;
    k_now     = edge_w ? '0 : k_q;
    k_nxt     = (k_now == CNT_W'(HALF_SLOTS - 1)) ? k_now : k_now + 1'b1;
    sm        = slot_map(use_fmt, k_now);
    nxt_word  = edge_w ? '0 : cur_q;
    if (sm.hit) nxt_word[sm.idx] = data_i;
    done_left = left_chan(act_fmt, prev_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_fmt   <= FMT_I2S;
      prev_w    <= 1'b0;
      synced    <= 1'b0;
      left_ok   <= 1'b0;
      k_q       <= '0;
      cur_q     <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (smp_i) begin
        act_fmt <= use_fmt;
        prev_w  <= wclk_i;
        k_q     <= k_nxt;
        cur_q   <= nxt_word;
        if (edge_w) begin
          synced <= 1'b1;
          if (synced) begin
            if (done_left) begin
              left_hold <= cur_q;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              left_o  <= left_hold;
              right_o <= cur_q;
              valid_o <= 1'b1;
              left_ok <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lnc_i,
  input  logic             wclk_i,
  input  fmt_e             fmt_i,
  input  logic             ld_i,
  input  logic [SMP_W-1:0] ld_left,
  input  logic [SMP_W-1:0] ld_right,
  output logic             sd_o
);
  fmt_e             act_fmt, use_fmt;
  logic             prev_w, active_q, edge_w, is_left, start_f, act_now, bit_now;
  logic [CNT_W-1:0] k_q, k_now, k_nxt;
  logic [SMP_W-1:0] hold_l, hold_r, cur_l, cur_r, word;
  slot_t            sm;

  always_comb begin
    edge_w  = (wclk_i != prev_w);
    use_fmt = edge_w ? fmt_i : act_fmt;
    k_now   = edge_w ? '0 : k_q;
    k_nxt   = (k_now == CNT_W'(HALF_SLOTS - 1)) ? k_now : k_now + 1'b1;
    is_left = left_chan(use_fmt, wclk_i);
    start_f = edge_w && is_left;
    act_now = active_q || start_f;
    word    = is_left ? (start_f ? hold_l : cur_l) : cur_r;
    sm      = slot_map(use_fmt, k_now);
    bit_now = act_now && sm.hit && word[sm.idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_fmt  <= FMT_I2S;
      prev_w   <= 1'b0;
      active_q <= 1'b0;
      k_q      <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      sd_o     <= 1'b0;
    end else begin
      if (ld_i) begin
        hold_l <= ld_left;
        hold_r <= ld_right;
      end
      if (lnc_i) begin
        act_fmt  <= use_fmt;
        prev_w   <= wclk_i;
        k_q      <= k_nxt;
        active_q <= act_now;
        sd_o     <= bit_now;
        if (start_f) begin
          cur_l <= hold_l;
          cur_r <= hold_r;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             wclk,
  input  logic             sdin,
  output logic             sdout,
  input  logic             bclk_fall,
  input  logic [1:0]       rx_fmt,
  input  logic [1:0]       tx_fmt,
  output logic [SMP_W-1:0] rx_left,
  output logic [SMP_W-1:0] rx_right,
  output logic             rx_valid,
  input  logic [SMP_W-1:0] tx_left,
  input  logic [SMP_W-1:0] tx_right,
  input  logic             tx_valid
);
  logic smp, lnc, wclk_s, sdin_s;

  asp_clk_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk     (clk),
    .rst     (rst),
    .bclk_i  (bclk),
    .wclk_i  (wclk),
    .data_i  (sdin),
    .fall_sel(bclk_fall),
    .smp_o   (smp),
    .lnc_o   (lnc),
    .wclk_o  (wclk_s),
    .data_o  (sdin_s)
  );

  asp_rx u_rx (
    .clk    (clk),
    .rst    (rst),
    .smp_i  (smp),
    .wclk_i (wclk_s),
    .data_i (sdin_s),
    .fmt_i  (fmt_e'(rx_fmt)),
    .left_o (rx_left),
    .right_o(rx_right),
    .valid_o(rx_valid)
  );

  asp_tx u_tx (
    .clk     (clk),
    .rst     (rst),
    .lnc_i   (lnc),
    .wclk_i  (wclk_s),
    .fmt_i   (fmt_e'(tx_fmt)),
    .ld_i    (tx_valid),
    .ld_left (tx_left),
    .ld_right(tx_right),
    .sd_o    (sdout)
  );
endmodule

// File: rtl/asp_chk.sv
module asp_chk
  import asp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             smp,
  input logic             lnc,
  input logic             sdout,
  input logic             rx_valid,
  input logic [SMP_W-1:0] rx_left,
  input logic [SMP_W-1:0] rx_right
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && !sdout));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9
  valid_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(smp));

  // R9
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({rx_left, rx_right}) |-> rx_valid);

  // R7
  launch_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $past(lnc));
endmodule

bind audio_serial_port asp_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .smp     (smp),
  .lnc     (lnc),
  .sdout   (sdout),
  .rx_valid(rx_valid),
  .rx_left (rx_left),
  .rx_right(rx_right)
);

// File: tb/sim_audio_serial_port.sv
module sim_audio_serial_port;
  localparam int PH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, wclk = 1'b0, sdin = 1'b0, bclk_fall = 1'b0, tx_valid = 1'b0;
  logic [1:0]  rx_fmt = 2'b00, tx_fmt = 2'b00;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic        sdout, rx_valid;
  logic [23:0] rx_left, rx_right;

  int          checks = 0, errors = 0, pulses = 0;
  logic [23:0] got_l = '0, got_r = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  audio_serial_port u0 (
    .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .sdin(sdin), .sdout(sdout),
    .bclk_fall(bclk_fall), .rx_fmt(rx_fmt), .tx_fmt(tx_fmt),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      pulses++;
      got_l = rx_left;
      got_r = rx_right;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit position for slot k under a format code, -1 outside the data field
  function automatic int b_pos(bit [1:0] f, int k);
    int s, n;
    case (f)
      2'd0: begin s = 1;  n = 24; end
      2'd1: begin s = 0;  n = 24; end
      2'd2: begin s = 8;  n = 24; end
      default: begin s = 12; n = 20; end
    endcase
    return (k >= s && k < s + n) ? 23 - (k - s) : -1;
  endfunction

  function automatic bit lft(bit [1:0] f);
    return f != 2'd0;
  endfunction

  function automatic logic [23:0] trim(bit [1:0] f, logic [23:0] w);
    return (f == 2'd3) ? {w[23:4], 4'h0} : w;
  endfunction

  task automatic half(input bit [1:0] frx, input bit [1:0] ftx, input bit lvl,
                      input logic [23:0] din, input bit chg, input bit [1:0] nrx,
                      input bit [1:0] ntx, input bit ld, input logic [23:0] nl,
                      input logic [23:0] nr, input bit rchk, input logic [23:0] pl,
                      input logic [23:0] pr, input bit clr, input string tag,
                      output logic [23:0] cap, output bit pad);
    cap = '0;
    pad = 1'b0;
    for (int k = 0; k < 32; k++) begin
      int pi, po;
      bit so;
      pi = b_pos(frx, k);
      @(negedge clk);
      bclk = bclk_fall;
      wclk = lvl;
      sdin = (pi >= 0) ? din[pi] : 1'($urandom);
      repeat (PH) @(negedge clk);
      bclk = ~bclk_fall;
      repeat (PH - 1) @(negedge clk);
      so = sdout;
      po = b_pos(ftx, k);
      if (po >= 0) cap[po] = so;
      else if (so) pad = 1'b1;
      if (k == 0) begin
        if (rchk) begin
          chk(pulses == 1, {tag, " R9 one strobe per frame"}, 24'(pulses), 24'd1);
          chk(got_l === pl, {tag, " R8 rx left"}, got_l, pl);
          chk(got_r === pr, {tag, " R8 rx right"}, got_r, pr);
        end
        if (clr) pulses = 0;
      end
      if (k == 16) begin
        if (chg) begin
          rx_fmt = nrx;
          tx_fmt = ntx;
        end
        if (ld) begin
          tx_left = nl;
          tx_right = nr;
          tx_valid = 1'b1;
          @(negedge clk);
          tx_valid = 1'b0;
        end
      end
    end
  endtask

  task automatic frame(input bit [1:0] rl, input bit [1:0] tl, input bit [1:0] rr,
                       input bit [1:0] tr, input logic [23:0] dl, input logic [23:0] dr,
                       input logic [23:0] el, input logic [23:0] er, input bit rchk,
                       input logic [23:0] pl, input logic [23:0] pr,
                       input logic [23:0] nl, input logic [23:0] nr, input string tag);
    logic [23:0] cl, cr;
    bit pdl, pdr;
    half(rl, tl, lft(rl), dl, 1'b1, rr, tr, 1'b0, '0, '0, rchk, pl, pr, 1'b1, tag, cl, pdl);
    half(rr, tr, ~lft(rr), dr, 1'b0, 2'd0, 2'd0, 1'b1, nl, nr, 1'b0, '0, '0, 1'b0, tag, cr, pdr);
    // R11: pair reloaded mid right half must not disturb this frame
    chk(cl === trim(tl, el), {tag, " R11 tx left"}, cl, trim(tl, el));
    chk(cr === trim(tr, er), {tag, " R11 tx right"}, cr, trim(tr, er));
    chk(!(pdl | pdr), {tag, " R8 pad slots zero"}, {22'd0, pdl, pdr}, 24'd0);
  endtask

  task automatic burst(input bit [1:0] rf, input bit [1:0] tf, input bit pol,
                       input int n, input string tag);
    logic [23:0] dl[8], dr[8], tl[8], tr[8];
    logic [23:0] cx;
    bit px;
    for (int i = 0; i < 8; i++) begin
      dl[i] = 24'($urandom);
      dr[i] = 24'($urandom);
      tl[i] = 24'($urandom);
      tr[i] = 24'($urandom);
    end
    dl[0] = 24'hFFFFFF;
    dr[0] = 24'h000001;
    tl[0] = 24'h800000;
    tr[0] = 24'h00000F;
    rx_fmt = rf;
    tx_fmt = tf;
    bclk_fall = pol;
    half(rf, tf, ~lft(rf), 24'($urandom), 1'b0, rf, tf, 1'b1, tl[0], tr[0],
         1'b0, '0, '0, 1'b0, tag, cx, px);
    for (int i = 0; i < n; i++) begin
      int j;
      j = (i > 0) ? i - 1 : 0;
      frame(rf, tf, rf, tf, dl[i], dr[i], tl[i], tr[i], i > 0,
            trim(rf, dl[j]), trim(rf, dr[j]), tl[i+1], tr[i+1], tag);
    end
    half(rf, tf, lft(rf), 24'($urandom), 1'b0, rf, tf, 1'b0, '0, '0,
         1'b1, trim(rf, dl[n-1]), trim(rf, dr[n-1]), 1'b1, tag, cx, px);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] a_l, a_r, b_l, b_r, x_l, x_r, y_l, y_r, cx;
    bit px;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_valid === 1'b0, "R1 rx_valid after reset", {23'd0, rx_valid}, 24'd0);
    chk(sdout === 1'b0, "R1 sdout after reset", {23'd0, sdout}, 24'd0);
    chk(rx_left === 24'd0, "R1 rx_left after reset", rx_left, 24'd0);
    chk(rx_right === 24'd0, "R1 rx_right after reset", rx_right, 24'd0);

    burst(2'd0, 2'd0, 1'b0, 4, "R2 i2s");
    burst(2'd1, 2'd1, 1'b0, 3, "R3 lj");
    burst(2'd2, 2'd2, 1'b0, 3, "R4 rj24");
    burst(2'd3, 2'd3, 1'b0, 3, "R5 rj20");
    burst(2'd1, 2'd3, 1'b0, 2, "R6 rx lj tx rj20");
    burst(2'd2, 2'd1, 1'b0, 2, "R6 rx rj24 tx lj");
    burst(2'd0, 2'd0, 1'b1, 3, "R7 i2s falling");
    burst(2'd3, 2'd2, 1'b1, 2, "R7 rj20/rj24 falling");

    // R10: format change in the middle of a left half-frame
    a_l = 24'hA5C3E1; a_r = 24'h13579B;
    b_l = 24'h2468AC; b_r = 24'hF0F0F0;
    x_l = 24'h9ABCDE; x_r = 24'h76543F;
    y_l = 24'h0FEDCB; y_r = 24'hC0FFE7;
    rx_fmt = 2'd1; tx_fmt = 2'd1; bclk_fall = 1'b0;
    half(2'd1, 2'd1, 1'b0, 24'($urandom), 1'b0, 2'd1, 2'd1, 1'b1, a_l, a_r,
         1'b0, '0, '0, 1'b0, "R10", cx, px);
    frame(2'd1, 2'd1, 2'd3, 2'd2, x_l, x_r, a_l, a_r, 1'b0, '0, '0, b_l, b_r, "R10 switch");
    frame(2'd3, 2'd2, 2'd3, 2'd2, y_l, y_r, b_l, b_r, 1'b1, x_l, trim(2'd3, x_r),
          24'd0, 24'd0, "R10 after");
    half(2'd3, 2'd2, 1'b1, 24'($urandom), 1'b0, 2'd3, 2'd2, 1'b0, '0, '0,
         1'b1, trim(2'd3, y_l), trim(2'd3, y_r), 1'b1, "R10 tail", cx, px);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule